// File: doc/BRIEF.md
# Parallel Printer Output Port

This block is a byte-wide parallel output port that sits on the I/O space of a small processor bus. The bus carries the same address and data lines it uses for memory. A separate I/O-select line marks a cycle as a port access. The block decodes three fixed ports out of a 1024-entry I/O space: a data port, a status port and a control port. Accesses to any other address, and any cycle with I/O-select low, get no response.

To send a byte, software first polls the status port until the ready flag in bit 7 reads 1. It then writes the byte to the data port, which drives the eight printer data lines and holds them until the next data write. Last, it writes 1 and then 0 to bit 0 of the control port, which produces a strobe pulse whose width software sets. The printer's ready input is asynchronous, so it passes through a two-flop synchroniser before it reaches the status port.

Top module: `lpt_port`

## Requirements
- R1: Reset (rst_n low) clears the data lines to 0x00 and drives the strobe low.
- R2: A write with io_sel high to port 0x378 drives wdata onto prn_data from the next clock edge. prn_data holds that value until the next such write.
- R3: A read with io_sel high of port 0x378 returns the last byte written there. A read of port 0x37A returns {7'b0, strobe}.
- R4: A read of port 0x379 returns the synchronised ready input in bit 7 and 0 in bits 6:0. A change on prn_ready shows in bit 7 after exactly two clock edges.
- R5: Bit 0 of a write to port 0x37A sets the strobe output, which holds until the next control write. Bits 7:1 of that write are discarded.
- R6: A write to the status port 0x379 changes neither prn_data nor the strobe.
- R7: With io_sel low, no write takes effect, hit stays 0 and rdata is 0x00, even at the three port addresses.
- R8: An access with io_sel high to any address other than 0x378 to 0x37A (0x37B, for example) leaves hit at 0 and rdata at 0x00, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | High when the bus cycle targets I/O space |
| io_addr | input | 10 | I/O port address |
| wr_en | input | 1 | Write strobe for the bus cycle |
| rd_en | input | 1 | Read strobe for the bus cycle |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data; 0x00 unless a read of one of the three ports is in progress |
| hit | output | 1 | High while an access decodes to one of the three ports |
| prn_data | output | 8 | Parallel data lines to the printer |
| prn_strobe | output | 1 | Strobe line to the printer |
| prn_ready | input | 1 | Asynchronous ready line from the printer (1 = can take a byte) |

## Verification
The bench targets the edges of the address decode. A memory cycle at a port address and an I/O cycle at 0x37B must both leave hit low and rdata at zero; a design that decodes too loosely would answer or latch on them. It writes 0xFF to the status port and then checks that the data lines and the strobe are unchanged, which catches a decoder that shares write enables between ports. It samples the ready flag one and two edges after a change, so a synchroniser one stage short, or one stage long, is caught. It also writes 0xFE to the control port to show that only bit 0 reaches the strobe.

// File: rtl/lpt_port.sv
module lpt_port #(
  parameter int          IO_AW     = 10,
  parameter int          DW        = 8,
  parameter logic [9:0]  BASE_PORT = 10'h378,
  parameter int          READY_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_sel,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             hit,
  output logic [DW-1:0]    prn_data,
  output logic             prn_strobe,
  input  logic             prn_ready
);
  localparam logic [IO_AW-1:0] DATA_PORT = IO_AW'(BASE_PORT);
  localparam logic [IO_AW-1:0] STAT_PORT = IO_AW'(BASE_PORT + 10'd1);
  localparam logic [IO_AW-1:0] CTRL_PORT = IO_AW'(BASE_PORT + 10'd2);

  logic sel_data, sel_stat, sel_ctrl, wr_data, wr_ctrl;
  logic [1:0] ready_sync;
  logic [DW-1:0] status_byte;

  assign sel_data = io_sel && (io_addr == DATA_PORT);
  assign sel_stat = io_sel && (io_addr == STAT_PORT);
  assign sel_ctrl = io_sel && (io_addr == CTRL_PORT);
  assign wr_data  = sel_data && wr_en;
  assign wr_ctrl  = sel_ctrl && wr_en;
  assign hit      = (sel_data || sel_stat || sel_ctrl) && (rd_en || wr_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prn_data   <= '0;
      prn_strobe <= 1'b0;
      ready_sync <= '0;
    end else begin
      ready_sync <= {ready_sync[0], prn_ready};
      if (wr_data) prn_data   <= wdata;
      if (wr_ctrl) prn_strobe <= wdata[0];
    end
  end

  always_comb begin
    status_byte = '0;
    status_byte[READY_BIT] = ready_sync[1];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel_data)      rdata = prn_data;
      else if (sel_stat) rdata = status_byte;
      else if (sel_ctrl) rdata = {{(DW-1){1'b0}}, prn_strobe};
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r2_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> prn_data == $past(wdata));
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(prn_data));
  a_r5_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(prn_strobe));
  a_r4_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_stat) |-> rdata[READY_BIT-1:0] == '0);
  a_r4_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> ready_sync[1] == $past(prn_ready, 2));
  a_r7_no_io_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel |-> (!hit && rdata == '0));
  a_r8_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && !sel_data && !sel_stat && !sel_ctrl) |-> (!hit && rdata == '0));
endmodule

// File: tb/lpt_port_test.sv
module lpt_port_test;
  logic clk = 0, rst_n = 0, io_sel = 0, wr_en = 0, rd_en = 0, prn_ready = 0;
  logic [9:0] io_addr = '0;
  logic [7:0] wdata = '0, rdata, prn_data;
  logic hit, prn_strobe;
  int n_run = 0, n_fail = 0;

  lpt_port uut (.clk, .rst_n, .io_sel, .io_addr, .wr_en, .rd_en, .wdata,
                .rdata, .hit, .prn_data, .prn_strobe, .prn_ready);

  always #4 clk = ~clk;

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic sel, logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    io_sel = sel; io_addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; io_sel = 0;
  endtask

  task automatic bus_rd(logic sel, logic [9:0] a, output logic [7:0] d, output logic h);
    @(negedge clk);
    io_sel = sel; io_addr = a; rd_en = 1;
    #1; d = rdata; h = hit;
    rd_en = 0; io_sel = 0;
  endtask

  task automatic t_reset;
    check("R1 data", {1'b0, prn_data}, 9'h000);
    check("R1 strobe", {8'b0, prn_strobe}, 9'h000);
  endtask

  task automatic t_data;
    logic [7:0] d; logic h;
    bus_wr(1, 10'h378, 8'hA5);
    check("R2 data lines", {1'b0, prn_data}, 9'h0A5);
    repeat (3) @(negedge clk);
    check("R2 hold", {1'b0, prn_data}, 9'h0A5);
    bus_rd(1, 10'h378, d, h);
    check("R3 readback", {h, d}, 9'h1A5);
    bus_wr(1, 10'h378, 8'h3C);
    check("R2 second byte", {1'b0, prn_data}, 9'h03C);
  endtask

  task automatic t_strobe;
    logic [7:0] d; logic h;
    bus_wr(1, 10'h37A, 8'h01);
    check("R5 strobe high", {8'b0, prn_strobe}, 9'h001);
    bus_rd(1, 10'h37A, d, h);
    check("R3 ctrl read", {h, d}, 9'h101);
    bus_wr(1, 10'h37A, 8'hFE);
    check("R5 strobe low, upper bits dropped", {8'b0, prn_strobe}, 9'h000);
    bus_rd(1, 10'h37A, d, h);
    check("R5 ctrl read zero", {h, d}, 9'h100);
  endtask

  task automatic t_status;
    logic [7:0] d; logic h;
    @(negedge clk); prn_ready = 1;
    bus_rd(1, 10'h379, d, h);
    check("R4 one edge", {h, d}, 9'h100);
    bus_rd(1, 10'h379, d, h);
    check("R4 two edges", {h, d}, 9'h180);
    @(negedge clk); prn_ready = 0;
    bus_rd(1, 10'h379, d, h);
    bus_rd(1, 10'h379, d, h);
    check("R4 ready low", {h, d}, 9'h100);
  endtask

  task automatic t_status_write;
    bus_wr(1, 10'h379, 8'hFF);
    check("R6 data kept", {1'b0, prn_data}, 9'h03C);
    check("R6 strobe kept", {8'b0, prn_strobe}, 9'h000);
  endtask

  task automatic t_no_io;
    logic [7:0] d; logic h;
    bus_wr(0, 10'h378, 8'h11);
    bus_wr(0, 10'h37A, 8'h01);
    check("R7 data kept", {1'b0, prn_data}, 9'h03C);
    check("R7 strobe kept", {8'b0, prn_strobe}, 9'h000);
    bus_rd(0, 10'h378, d, h);
    check("R7 no response", {h, d}, 9'h000);
  endtask

  task automatic t_miss;
    logic [7:0] d; logic h;
    bus_wr(1, 10'h37B, 8'h77);
    bus_wr(1, 10'h278, 8'h01);
    check("R8 data kept", {1'b0, prn_data}, 9'h03C);
    check("R8 strobe kept", {8'b0, prn_strobe}, 9'h000);
    bus_rd(1, 10'h37B, d, h);
    check("R8 no response 37B", {h, d}, 9'h000);
    bus_rd(1, 10'h377, d, h);
    check("R8 no response 377", {h, d}, 9'h000);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_data();
    t_strobe();
    t_status();
    t_status_write();
    t_no_io();
    t_miss();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule